// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two WIDTH-bit integers over several clock cycles and returns a 2·WIDTH-bit product. A one-cycle `start` pulse samples both operands and a signed/unsigned select. The block then adds one partial product per cycle into a double-width accumulator. When the last multiplier bit has been consumed, the accumulator is copied into two result registers. The high register holds the upper half of the product and the low register holds the lower half. Each half has its own read port, so a move-from-high and a move-from-low can be served independently.

In signed mode, the multiplicand is sign-extended to the full product width before any partial product is formed. The multiplier's top bit carries negative weight, so its partial product is subtracted instead of added. In unsigned mode, the multiplicand is zero-extended and every partial product is added. `busy` covers the whole operation. `done` marks completion for exactly one cycle. The result registers keep their value until the next operation completes. WIDTH defaults to 32 and can be reduced to 4 so that every operand pair can be tested.

Top module: `seq_multiplier`

## Requirements
- R1: In unsigned mode (`signedMode`=0 at start), the completed result {hiOut,loOut} equals opA×opB, with both operands taken as unsigned WIDTH-bit values. The result is a 2·WIDTH-bit product (4-bit example: 15×15 = 0xE1).
- R2: In signed mode (`signedMode`=1 at start), {hiOut,loOut} equals the two's-complement product of the operands, as a 2·WIDTH-bit value (4-bit example: 5×(−3) = 0xF1).
- R3: `hiOut` carries bits [2·WIDTH−1:WIDTH] of the product and `loOut` carries bits [WIDTH−1:0].
- R4: The edge that accepts `start` is counted as edge 1. `done` rises after edge WIDTH+2. `busy` is high from edge 1 until that same edge.
- R5: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R6: `hiOut` and `loOut` change only at completion. They are not affected by operand or mode changes without an accepted start.
- R7: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands, its mode and its completion time.
- R8: Reset (`rstN` low, asynchronous) clears `hiOut`, `loOut`, `busy` and `done`.
- R9: In signed mode, the most negative value times itself gives +2^(2·WIDTH−2) (4-bit: −8×−8 = 0x40). The most negative value times the largest positive value gives the correct negative product (4-bit: −8×7 = 0xC8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when the block is idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned; sampled at start |
| opA | input | WIDTH | Multiplicand |
| opB | input | WIDTH | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| hiOut | output | WIDTH | Upper half of the last product |
| loOut | output | WIDTH | Lower half of the last product |

## Verification
The checker watches the handshake on every cycle:
- `done` lasts one cycle and never overlaps `busy`.
- The busy window has the exact length given in R4.
- A running operation cannot be cut short by a second start.
- The result registers move only in a completion cycle.

Whether the product values are correct can only be shown by the bench's scenarios. These are a table of chosen signed and unsigned operand pairs, followed by an exhaustive sweep at WIDTH=4. Directed cases add three checks: a start injected mid-operation with different operands and mode, operand changes while idle, and reset applied during a run.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Strobes from the sequencer to the datapath, one per cycle.
  typedef struct packed {
    logic load;     // capture operands, clear accumulator
    logic step;     // accumulate one partial product
    logic negStep;  // this step subtracts (signed top multiplier bit)
    logic commit;   // copy accumulator to result registers
  } smul_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_COMMIT = 2'd2
  } smul_state_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      signedMode,
  output smul_ctl_t ctl,
  output logic      busy,
  output logic      done
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  smul_state_e state;
  logic [CW-1:0] stepCnt;
  logic          sgnLatch;
  logic          busyQ;
  logic          doneQ;

  // Strobes decoded from the current state.
  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && start;
    ctl.step    = (state == ST_RUN);
    ctl.negStep = (state == ST_RUN) && sgnLatch && (stepCnt == LAST_STEP);
    ctl.commit  = (state == ST_COMMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      sgnLatch <= 1'b0;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            stepCnt  <= '0;
            sgnLatch <= signedMode;
            busyQ    <= 1'b1;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + CW'(1);
          if (stepCnt == LAST_STEP) state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          state <= ST_IDLE;
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/smul_dp.sv
module smul_dp
  import smul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  smul_ctl_t        ctl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    mcand;    // shifted, extended multiplicand
  logic [WIDTH-1:0] mplier;   // multiplier, consumed from bit 0
  logic [PW-1:0]    acc;
  logic [PW-1:0]    partProd;
  logic [PW-1:0]    accNext;
  logic [PW-1:0]    extA;
  logic [WIDTH-1:0] hiQ;
  logic [WIDTH-1:0] loQ;

  // Extend the multiplicand to full product width; signed mode replicates the sign.
  assign extA = signedMode ? {{WIDTH{opA[WIDTH-1]}}, opA}
                           : {{WIDTH{1'b0}}, opA};

  // Partial product: multiplicand gated by the current multiplier bit.
  for (genvar g = 0; g < PW; g++) begin : gPartial
    assign partProd[g] = mcand[g] & mplier[0];
  end

  assign accNext = ctl.negStep ? (acc - partProd) : (acc + partProd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      hiQ    <= '0;
      loQ    <= '0;
    end else begin
      if (ctl.load) begin
        mcand  <= extA;
        mplier <= opB;
        acc    <= '0;
      end else if (ctl.step) begin
        acc    <= accNext;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
      end
      if (ctl.commit) begin
        hiQ <= acc[PW-1:WIDTH];
        loQ <= acc[WIDTH-1:0];
      end
    end
  end

  assign hiOut = hiQ;
  assign loOut = loQ;

endmodule

// File: rtl/seq_multiplier.sv
module seq_multiplier
  import smul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  smul_ctl_t ctl;

  smul_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .signedMode (signedMode),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done)
  );

  smul_dp #(.WIDTH(WIDTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .signedMode (signedMode),
    .opA        (opA),
    .opB        (opB),
    .hiOut      (hiOut),
    .loOut      (loOut)
  );

endmodule

// File: rtl/seq_multiplier_chk.sv
module seq_multiplier_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut
);

  localparam int unsigned RUN_LEN = WIDTH + 1;

  // Counts cycles spent busy; window checked by counter, not by $past depth.
  int unsigned busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyRun == RUN_LEN));  // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hiOut) && $stable(loOut)));  // R6
  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && busyRun < RUN_LEN) |=> busy);  // R7

endmodule

bind seq_multiplier seq_multiplier_chk #(.WIDTH(WIDTH)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .hiOut (hiOut),
  .loOut (loOut)
);

// File: tb/sim_seq_multiplier.sv
`timescale 1ns/1ps
module sim_seq_multiplier;

  localparam int W = 4;
  localparam int EXP_LAT = W + 2;

  typedef struct packed {
    logic       sgn;
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] prod;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'h5, 4'h3, 8'h0F},
    '{1'b0, 4'hF, 4'hF, 8'hE1},
    '{1'b0, 4'h0, 4'hD, 8'h00},
    '{1'b0, 4'h1, 4'h9, 8'h09},
    '{1'b0, 4'hC, 4'hA, 8'h78},
    '{1'b0, 4'h8, 4'h8, 8'h40},
    '{1'b1, 4'h5, 4'hD, 8'hF1},
    '{1'b1, 4'h8, 4'h8, 8'h40},
    '{1'b1, 4'h8, 4'h7, 8'hC8},
    '{1'b1, 4'h7, 4'hF, 8'hF9},
    '{1'b1, 4'hF, 4'hF, 8'h01},
    '{1'b1, 4'h3, 4'h8, 8'hE8}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         busy, done;
  logic [W-1:0] hiOut, loOut;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  seq_multiplier #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  // Starts one operation; returns the product and the number of edges until done is seen.
  task automatic runOp(input logic s, input logic [3:0] a, input logic [3:0] b,
                       output logic [7:0] res, output int lat);
    @(negedge clk);
    signedMode = s; opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    res = {hiOut, loOut};
  endtask

  function automatic logic [7:0] refProd(input logic s, input logic [3:0] a, input logic [3:0] b);
    int sa = int'(a);
    int sb = int'(b);
    if (s && a[3]) sa = sa - 16;
    if (s && b[3]) sb = sb - 16;
    return 8'(sa * sb);
  endfunction

  initial begin
    #500000;
    if (!finished) begin
      nFail++;
      $display("FAIL R4 watchdog: actual=hung expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] res;
    int lat;
    logic [7:0] held;

    repeat (3) @(negedge clk);
    // R8: state under reset
    check(busy == 1'b0 && done == 1'b0, "R8 reset busy/done", {busy, done}, 0);
    check(hiOut == '0 && loOut == '0, "R8 reset hi/lo", {hiOut, loOut}, 0);
    rstN = 1'b1;

    // Table walk: R1, R2, R3, R4, R9
    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i].sgn, VECS[i].a, VECS[i].b, res, lat);
      check(res == VECS[i].prod, VECS[i].sgn ? "R2/R9 table product" : "R1 table product",
            res, VECS[i].prod);
      check(hiOut == VECS[i].prod[7:4], "R3 hi half", hiOut, VECS[i].prod[7:4]);
      check(loOut == VECS[i].prod[3:0], "R3 lo half", loOut, VECS[i].prod[3:0]);
      check(lat == EXP_LAT, "R4 latency", lat, EXP_LAT);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R5 done single cycle", {busy, done}, 0);
    end

    // Exhaustive sweep, both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          runOp(s[0], 4'(a), 4'(b), res, lat);
          check(res == refProd(s[0], 4'(a), 4'(b)), s ? "R2 sweep" : "R1 sweep",
                res, refProd(s[0], 4'(a), 4'(b)));
        end
      end
    end

    // R6: operand and mode changes without start leave hi/lo untouched
    runOp(1'b0, 4'hB, 4'h7, res, lat);  // 77 = 0x4D
    held = {hiOut, loOut};
    @(negedge clk);
    opA = 4'h2; opB = 4'h3; signedMode = 1'b1;
    repeat (4) @(negedge clk);
    check({hiOut, loOut} == held, "R6 hold while idle", {hiOut, loOut}, held);
    check(busy == 1'b0, "R6 no start taken", busy, 0);

    // R7: second start while busy ignored (different operands and mode)
    @(negedge clk);
    signedMode = 1'b0; opA = 4'h3; opB = 4'h5; start = 1'b1;
    @(negedge clk);
    start = 1'b1; opA = 4'hF; opB = 4'hF; signedMode = 1'b1;
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check({hiOut, loOut} == 8'h0F, "R7 operands kept", {hiOut, loOut}, 8'h0F);
    check(lat == EXP_LAT, "R7 completion time kept", lat, EXP_LAT);
    @(negedge clk);
    check(busy == 1'b0, "R7 no restart", busy, 0);

    // R8: reset during an operation after a non-zero result
    runOp(1'b0, 4'hF, 4'hF, res, lat);
    @(negedge clk);
    signedMode = 1'b0; opA = 4'h9; opB = 4'h9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(busy == 1'b0 && done == 1'b0, "R8 mid-run reset busy/done", {busy, done}, 0);
    check(hiOut == '0 && loOut == '0, "R8 mid-run reset hi/lo", {hiOut, loOut}, 0);
    @(negedge clk);
    rstN = 1'b1;
    runOp(1'b1, 4'h5, 4'hD, res, lat);
    check(res == 8'hF1, "R2 after reset", res, 8'hF1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule